// File: doc/BRIEF.md
# Evolutionary Configuration-Word Search Engine

This block searches for a short configuration word, a chromosome of a few bits, that makes a reconfigurable logic cell behave as required. It keeps a small population of candidate words in registers. The first population is seeded from an on-chip linear feedback shift register. Each candidate goes out over a request/response handshake to an external evaluator, which returns an unsigned fitness score. The block never judges a candidate itself.

After every candidate in a generation has a score, the engine picks two parents. Any individual whose share of the generation's total fitness is above eight tenths becomes both parents. If no individual reaches that share, the two best scorers are the parents. The engine then breeds a new generation pair by pair. Cut-point crossover is gated by a random draw compared against a crossover-probability input. Single-bit mutation is gated by a second, separate draw compared against a mutation-probability input.

The search stops when a candidate's score equals the maximum-score input, or when the generation budget is used up. It then raises `done` and holds the best chromosome seen together with its score, until software or a sequencer pulses `start` again.

Top module: `ga_search_engine`

## Requirements
- R1: After reset `done` and `fit_req` are low, and `best_chrom` and `best_score` are zero.
- R2: While `fit_req` is high and `fit_valid` is low, `fit_req` stays high and `fit_chrom` holds its value. A `fit_valid` pulse while `fit_req` is low changes neither `done`, `best_chrom` nor `best_score`.
- R3: One `start` pulse fills the population with pseudo-random words. Every generation then requests exactly POP evaluations, in population index order from 0 to POP-1.
- R4: An individual qualifies when score*10 > generation_sum*8. If one qualifies, the lowest-indexed qualifier is used as both parents.
- R5: With no qualifier, parent A is the highest scorer and parent B is the highest scorer among the rest. On equal scores the lower index wins.
- R6: Offspring of pair j are stored at index 2j (derived from parent A) and at index 2j+1 (derived from parent B). With crossover probability 0 and mutation probability 0, every offspring equals its own parent.
- R7: When crossover is taken, there is a cut point k from 0 to GENES-1. Offspring A is parent A with its k low bits replaced by parent B's, and offspring B is the mirror image.
- R8: Mutation inverts at most one bit in each offspring, and only when a draw falls below the mutation probability. With probability 0, no bit is inverted.
- R9: An accepted score equal to `max_score` raises `done` on the next clock. At that point `best_chrom` and `best_score` hold that candidate and its score.
- R10: If no maximum score is met, `done` rises after max(`gen_limit`,1) generations have been evaluated.
- R11: `best_chrom` and `best_score` hold the highest score seen since `start`. On equal scores the earliest candidate is kept.
- R12: `done` stays high until `start`. The cycle after `start` is taken, `done` is low and `best_score` is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a new search (taken when idle or done) |
| cross_prob | input | PROB_W | Crossover probability (draw < value performs crossover) |
| mut_prob | input | PROB_W | Mutation probability (draw < value performs mutation) |
| gen_limit | input | GEN_W | Generation budget |
| max_score | input | FIT_W | Score that ends the search at once |
| fit_req | output | 1 | Evaluation request outstanding |
| fit_chrom | output | GENES | Chromosome to evaluate |
| fit_valid | input | 1 | Evaluator result strobe |
| fit_score | input | FIT_W | Evaluator score |
| done | output | 1 | Search finished |
| best_chrom | output | GENES | Best chromosome seen |
| best_score | output | FIT_W | Score of the best chromosome |

## Verification
The bench takes each first generation as observed and works out the parents independently. It then requires the second generation to follow from them under the two extreme probability settings. A selector with a wrong tie order, a wrong share threshold or swapped parents would request the wrong words in generation two. Crossover is checked for a legal cut that reproduces both offspring, so a swap at the wrong end or a one-sided exchange would fail. Mutation is checked for a Hamming distance of at most one. The bench also exercises an early stop on the third candidate, a zero generation budget, equal-score ties for the best word, a stray result strobe while idle, and a restart after `done`. A design that stopped a cycle late, lost the first-seen tie or leaked the stray score would each miscount or misreport.

// File: rtl/ga_pkg.sv
package ga_pkg;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_INIT,
      ST_EVAL,
      ST_SEL,
      ST_BREED,
      ST_DONE
   } ga_state_t;

   // Galois feedback masks for maximal-length sequences of supported widths
   function automatic logic [31:0] lfsr_taps(input int width);
      case (width)
         8:       return 32'h0000_00B8;
         16:      return 32'h0000_B400;
         default: return 32'h8020_0003;
      endcase
   endfunction

endpackage

// File: rtl/ga_lfsr.sv
module ga_lfsr #(
   parameter int          W    = 16,
   parameter logic [31:0] SEED = 32'h0000_ACE1
) (
   input  logic         clk,
   input  logic         rst_n,
   output logic [W-1:0] rnd
);
   import ga_pkg::*;

   localparam logic [W-1:0] TAPS     = W'(lfsr_taps(W));
   localparam logic [W-1:0] SEED_VAL = W'(SEED);

   generate
      if (W != 8 && W != 16 && W != 32) begin : g_bad_width
         $error("ga_lfsr: width must be 8, 16 or 32");
      end
      if (SEED_VAL == '0) begin : g_bad_seed
         $error("ga_lfsr: seed must be nonzero");
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         rnd <= SEED_VAL;
      else if (rnd[0])
         rnd <= (rnd >> 1) ^ TAPS;
      else
         rnd <= rnd >> 1;
   end

endmodule

// File: rtl/ga_parent_select.sv
module ga_parent_select #(
   parameter int POP   = 8,
   parameter int FIT_W = 8,
   parameter int IDX_W = 3,
   parameter int SUM_W = 11
) (
   input  logic [POP*FIT_W-1:0] scores,
   input  logic [SUM_W-1:0]     total,
   output logic [IDX_W-1:0]     par_a,
   output logic [IDX_W-1:0]     par_b
);
   localparam int CMP_W = SUM_W + 4;

   logic             qual_found;
   logic [IDX_W-1:0] qual_idx;
   int               b1, b2;
   logic [CMP_W-1:0] limit;

   always_comb begin
      limit      = CMP_W'(total) * CMP_W'(8);
      qual_found = 1'b0;
      qual_idx   = '0;
      for (int i = POP - 1; i >= 0; i--) begin
         if (CMP_W'(scores[i*FIT_W +: FIT_W]) * CMP_W'(10) > limit) begin
            qual_found = 1'b1;
            qual_idx   = IDX_W'(i);
         end
      end
   end

   always_comb begin
      if (scores[FIT_W +: FIT_W] > scores[0 +: FIT_W]) begin
         b1 = 1;
         b2 = 0;
      end else begin
         b1 = 0;
         b2 = 1;
      end
      for (int i = 2; i < POP; i++) begin
         if (scores[i*FIT_W +: FIT_W] > scores[b1*FIT_W +: FIT_W]) begin
            b2 = b1;
            b1 = i;
         end else if (scores[i*FIT_W +: FIT_W] > scores[b2*FIT_W +: FIT_W]) begin
            b2 = i;
         end
      end
   end

   assign par_a = qual_found ? qual_idx : IDX_W'(b1);
   assign par_b = qual_found ? qual_idx : IDX_W'(b2);

endmodule

// File: rtl/ga_breeder.sv
module ga_breeder #(
   parameter int GENES  = 5,
   parameter int PROB_W = 8,
   parameter int RAND_W = 16
) (
   input  logic [GENES-1:0]  par_a,
   input  logic [GENES-1:0]  par_b,
   input  logic [RAND_W-1:0] rnd,
   input  logic [PROB_W-1:0] cross_prob,
   input  logic [PROB_W-1:0] mut_prob,
   output logic [GENES-1:0]  kid_a,
   output logic [GENES-1:0]  kid_b
);
   localparam int POS_W = (GENES > 1) ? $clog2(GENES) : 1;

   generate
      if (RAND_W < 2 * PROB_W || RAND_W < 12) begin : g_bad_rand
         $error("ga_breeder: random word too narrow for the draws");
      end
   endgenerate

   logic [PROB_W-1:0] x_draw, m_draw;
   logic [POS_W-1:0]  cut, pos_a, pos_b;
   logic [GENES-1:0]  low_mask, xa, xb;

   assign x_draw = rnd[PROB_W-1:0];
   assign m_draw = rnd[2*PROB_W-1:PROB_W];
   assign cut    = POS_W'(rnd[RAND_W-1 -: 8] % 8'(GENES));
   assign pos_a  = POS_W'(rnd[RAND_W-3 -: 8] % 8'(GENES));
   assign pos_b  = POS_W'(rnd[RAND_W-5 -: 8] % 8'(GENES));

   always_comb begin
      low_mask = GENES'((32'd1 << cut) - 32'd1);
      if (x_draw < cross_prob) begin
         xa = (par_a & ~low_mask) | (par_b & low_mask);
         xb = (par_b & ~low_mask) | (par_a & low_mask);
      end else begin
         xa = par_a;
         xb = par_b;
      end
      if (m_draw < mut_prob) begin
         kid_a = xa ^ (GENES'(1) << pos_a);
         kid_b = xb ^ (GENES'(1) << pos_b);
      end else begin
         kid_a = xa;
         kid_b = xb;
      end
   end

endmodule

// File: rtl/ga_search_engine.sv
module ga_search_engine #(
   parameter int          GENES  = 5,
   parameter int          POP    = 8,
   parameter int          FIT_W  = 8,
   parameter int          PROB_W = 8,
   parameter int          GEN_W  = 16,
   parameter int          LFSR_W = 16,
   parameter logic [31:0] SEED   = 32'h0000_ACE1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic [PROB_W-1:0] cross_prob,
   input  logic [PROB_W-1:0] mut_prob,
   input  logic [GEN_W-1:0]  gen_limit,
   input  logic [FIT_W-1:0]  max_score,
   output logic              fit_req,
   output logic [GENES-1:0]  fit_chrom,
   input  logic              fit_valid,
   input  logic [FIT_W-1:0]  fit_score,
   output logic              done,
   output logic [GENES-1:0]  best_chrom,
   output logic [FIT_W-1:0]  best_score
);
   import ga_pkg::*;

   localparam int IDX_W  = (POP > 1) ? $clog2(POP) : 1;
   localparam int SUM_W  = FIT_W + IDX_W;
   localparam int PAIRS  = POP / 2;
   localparam int PAIR_W = (PAIRS > 1) ? $clog2(PAIRS) : 1;

   generate
      if (POP < 2 || (POP % 2) != 0) begin : g_bad_pop
         $error("ga_search_engine: POP must be even and at least 2");
      end
      if (GENES < 2 || LFSR_W < GENES) begin : g_bad_genes
         $error("ga_search_engine: GENES out of range");
      end
   endgenerate

   ga_state_t             state;
   logic [IDX_W-1:0]      idx;
   logic [PAIR_W-1:0]     pair;
   logic [GEN_W-1:0]      gen_cnt;
   logic [SUM_W-1:0]      sum_q;
   logic                  have_best;
   logic [GENES-1:0]      pop_q   [POP];
   logic [FIT_W-1:0]      score_q [POP];
   logic [POP*FIT_W-1:0]  score_flat;
   logic [GENES-1:0]      pa_q, pb_q, kid_a, kid_b;
   logic [IDX_W-1:0]      sel_a, sel_b;
   logic [LFSR_W-1:0]     rnd;
   logic [IDX_W-1:0]      wr_even;

   genvar gi;
   generate
      for (gi = 0; gi < POP; gi++) begin : g_flat
         assign score_flat[gi*FIT_W +: FIT_W] = score_q[gi];
      end
   endgenerate

   ga_lfsr #(.W(LFSR_W), .SEED(SEED)) u_lfsr (
      .clk   (clk),
      .rst_n (rst_n),
      .rnd   (rnd)
   );

   ga_parent_select #(.POP(POP), .FIT_W(FIT_W), .IDX_W(IDX_W), .SUM_W(SUM_W)) u_select (
      .scores (score_flat),
      .total  (sum_q),
      .par_a  (sel_a),
      .par_b  (sel_b)
   );

   ga_breeder #(.GENES(GENES), .PROB_W(PROB_W), .RAND_W(LFSR_W)) u_breed (
      .par_a      (pa_q),
      .par_b      (pb_q),
      .rnd        (rnd),
      .cross_prob (cross_prob),
      .mut_prob   (mut_prob),
      .kid_a      (kid_a),
      .kid_b      (kid_b)
   );

   assign wr_even   = IDX_W'({pair, 1'b0});
   assign fit_req   = (state == ST_EVAL);
   assign fit_chrom = pop_q[idx];
   assign done      = (state == ST_DONE);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state      <= ST_IDLE;
         idx        <= '0;
         pair       <= '0;
         gen_cnt    <= '0;
         sum_q      <= '0;
         have_best  <= 1'b0;
         best_chrom <= '0;
         best_score <= '0;
         pa_q       <= '0;
         pb_q       <= '0;
         for (int i = 0; i < POP; i++) begin
            pop_q[i]   <= '0;
            score_q[i] <= '0;
         end
      end else begin
         case (state)
            ST_IDLE, ST_DONE: begin
               if (start) begin
                  state      <= ST_INIT;
                  idx        <= '0;
                  gen_cnt    <= '0;
                  have_best  <= 1'b0;
                  best_chrom <= '0;
                  best_score <= '0;
               end
            end
            ST_INIT: begin
               pop_q[idx] <= rnd[GENES-1:0];
               if (idx == IDX_W'(POP - 1)) begin
                  idx   <= '0;
                  sum_q <= '0;
                  state <= ST_EVAL;
               end else begin
                  idx <= idx + 1'b1;
               end
            end
            ST_EVAL: begin
               if (fit_valid) begin
                  score_q[idx] <= fit_score;
                  sum_q        <= sum_q + SUM_W'(fit_score);
                  have_best    <= 1'b1;
                  if (!have_best || fit_score > best_score) begin
                     best_chrom <= pop_q[idx];
                     best_score <= fit_score;
                  end
                  if (fit_score == max_score) begin
                     state <= ST_DONE;
                  end else if (idx == IDX_W'(POP - 1)) begin
                     idx   <= '0;
                     state <= ST_SEL;
                  end else begin
                     idx <= idx + 1'b1;
                  end
               end
            end
            ST_SEL: begin
               pa_q    <= pop_q[sel_a];
               pb_q    <= pop_q[sel_b];
               gen_cnt <= gen_cnt + 1'b1;
               if (({1'b0, gen_cnt} + 1'b1) >= {1'b0, gen_limit}) begin
                  state <= ST_DONE;
               end else begin
                  pair  <= '0;
                  state <= ST_BREED;
               end
            end
            ST_BREED: begin
               pop_q[wr_even]        <= kid_a;
               pop_q[wr_even + 1'b1] <= kid_b;
               if (pair == PAIR_W'(PAIRS - 1)) begin
                  idx   <= '0;
                  sum_q <= '0;
                  state <= ST_EVAL;
               end else begin
                  pair <= pair + 1'b1;
               end
            end
            default: state <= ST_IDLE;
         endcase
      end
   end

endmodule

// File: rtl/ga_search_checker.sv
module ga_search_checker #(
   parameter int GENES = 5,
   parameter int FIT_W = 8
) (
   input logic             clk,
   input logic             rst_n,
   input logic             start,
   input logic [FIT_W-1:0] max_score,
   input logic             fit_req,
   input logic [GENES-1:0] fit_chrom,
   input logic             fit_valid,
   input logic [FIT_W-1:0] fit_score,
   input logic             done,
   input logic [GENES-1:0] best_chrom,
   input logic [FIT_W-1:0] best_score
);

   assert_req_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (fit_req && !fit_valid) |=> (fit_req && $stable(fit_chrom)));

   assert_stray_valid_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (!fit_req && !start) |=> ($stable(best_score) && $stable(best_chrom)));

   assert_stop_on_max_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (fit_req && fit_valid && fit_score == max_score) |=>
         (done && best_chrom == $past(fit_chrom) && best_score == $past(fit_score)));

   assert_best_monotonic_R11: assert property (@(posedge clk) disable iff (!rst_n)
      (!start) |=> (best_score >= $past(best_score)));

   assert_done_hold_R12: assert property (@(posedge clk) disable iff (!rst_n)
      (done && !start) |=> done);

   assert_restart_R12: assert property (@(posedge clk) disable iff (!rst_n)
      (done && start) |=> (!done && best_score == '0));

endmodule

bind ga_search_engine ga_search_checker #(.GENES(GENES), .FIT_W(FIT_W)) u_checker (
   .clk        (clk),
   .rst_n      (rst_n),
   .start      (start),
   .max_score  (max_score),
   .fit_req    (fit_req),
   .fit_chrom  (fit_chrom),
   .fit_valid  (fit_valid),
   .fit_score  (fit_score),
   .done       (done),
   .best_chrom (best_chrom),
   .best_score (best_score)
);

// File: tb/tb_ga_search_engine.sv
module tb_ga_search_engine;
   localparam int GENES = 5;
   localparam int POP   = 8;

   logic             clk = 1'b0;
   logic             rst_n = 1'b0;
   logic             start = 1'b0;
   logic [7:0]       cross_prob = '0, mut_prob = '0, max_score = 8'hFF;
   logic [15:0]      gen_limit = 16'd1;
   logic             fit_req, fit_valid = 1'b0, done;
   logic [GENES-1:0] fit_chrom, best_chrom;
   logic [7:0]       fit_score = '0, best_score;

   always #5 clk = ~clk;

   ga_search_engine dut (
      .clk(clk), .rst_n(rst_n), .start(start), .cross_prob(cross_prob),
      .mut_prob(mut_prob), .gen_limit(gen_limit), .max_score(max_score),
      .fit_req(fit_req), .fit_chrom(fit_chrom), .fit_valid(fit_valid),
      .fit_score(fit_score), .done(done), .best_chrom(best_chrom),
      .best_score(best_score)
   );

   int               n_chk = 0, n_fail = 0;
   int               mode = 0, nreq = 0;
   bit               resp_on = 1'b0;
   logic [GENES-1:0] req_log [$];
   logic [GENES-1:0] exp_q   [$];

   task automatic check(input bit ok, input string req, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   function automatic int score_fn(input logic [GENES-1:0] c, input int k);
      case (mode)
         0:       return (k % POP == 0) ? 250 : 2;
         1:       return int'(c) * 3 + 1;
         2:       return (k == 2) ? 77 : 5;
         default: return (int'(c) % 4) * 10 + 1;
      endcase
   endfunction

   // monitor/responder: answers each request with a varying latency
   initial begin : responder
      logic [GENES-1:0] c;
      forever begin
         @(negedge clk);
         if (resp_on && fit_valid) begin
            fit_valid = 1'b0;
         end else if (resp_on && fit_req) begin
            c = fit_chrom;
            repeat (nreq % 3) @(negedge clk);
            check(fit_req && fit_chrom == c, "R2 request held", int'(fit_chrom), int'(c));
            fit_score = 8'(score_fn(c, nreq));
            req_log.push_back(c);
            nreq++;
            fit_valid = 1'b1;
         end
      end
   end

   task automatic run(input int m, input int cp, input int mp, input int gl, input int ms);
      mode = m; cross_prob = 8'(cp); mut_prob = 8'(mp);
      gen_limit = 16'(gl); max_score = 8'(ms);
      req_log.delete(); nreq = 0; resp_on = 1'b1;
      @(negedge clk); start = 1'b1;
      @(negedge clk); start = 1'b0;
      wait (done === 1'b1);
      @(negedge clk); @(negedge clk);
      resp_on = 1'b0; fit_valid = 1'b0;
   endtask

   // expected parents from the first generation, per the selection rules
   task automatic pick(output logic [GENES-1:0] pa, output logic [GENES-1:0] pb);
      int s [POP];
      int sum = 0, q = -1, b1 = 0, b2;
      for (int i = 0; i < POP; i++) begin s[i] = score_fn(req_log[i], i); sum += s[i]; end
      for (int i = 0; i < POP; i++) if (q < 0 && s[i] * 10 > sum * 8) q = i;
      if (q >= 0) begin pa = req_log[q]; pb = pa; return; end
      for (int i = 0; i < POP; i++) if (s[i] > s[b1]) b1 = i;
      b2 = (b1 == 0) ? 1 : 0;
      for (int i = 0; i < POP; i++) if (i != b1 && s[i] > s[b2]) b2 = i;
      pa = req_log[b1]; pb = req_log[b2];
   endtask

   task automatic push_expected(input logic [GENES-1:0] pa, input logic [GENES-1:0] pb);
      for (int j = 0; j < POP / 2; j++) begin exp_q.push_back(pa); exp_q.push_back(pb); end
   endtask

   task automatic compare_gen2(input string req);
      for (int i = 0; i < POP; i++) begin
         logic [GENES-1:0] e;
         e = exp_q.pop_front();
         check(req_log[POP + i] == e, req, int'(req_log[POP + i]), int'(e));
      end
   endtask

   initial begin : watchdog
      repeat (190000) @(posedge clk);
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

   initial begin : main
      logic [GENES-1:0] pa, pb, m, c0, c1, bc;
      int               bs, distinct;
      bit               ok;
      repeat (3) @(negedge clk);
      // R1 reset state
      check(done == 0 && fit_req == 0, "R1 flags", int'({done, fit_req}), 0);
      check(best_chrom == 0 && best_score == 0, "R1 best", int'(best_score), 0);
      rst_n = 1'b1;
      @(negedge clk);

      // R2 stray result strobe while idle
      max_score = 8'hFF; fit_score = 8'hFF; fit_valid = 1'b1;
      @(negedge clk); fit_valid = 1'b0;
      @(negedge clk);
      check(done == 0 && best_score == 0, "R2 stray valid", int'(best_score), 0);

      // R4 qualifier used as both parents; R3 count and seeding
      run(0, 0, 0, 2, 255);
      check(req_log.size() == 2 * POP, "R3 requests per generation", req_log.size(), 2 * POP);
      distinct = 0;
      for (int i = 1; i < POP; i++) if (req_log[i] != req_log[0]) distinct++;
      check(distinct > 0, "R3 seeded population varies", distinct, 1);
      pick(pa, pb);
      check(pa == req_log[0] && pb == req_log[0], "R4 qualifier chosen", int'(pa), int'(req_log[0]));
      push_expected(pa, pb);
      compare_gen2("R4 offspring copy qualifier");

      // R5/R6 top two parents, no crossover or mutation
      run(1, 0, 0, 2, 255);
      pick(pa, pb);
      push_expected(pa, pb);
      compare_gen2("R5 R6 offspring from top two");

      // R7 crossover always
      run(1, 255, 0, 2, 255);
      pick(pa, pb);
      for (int j = 0; j < POP / 2; j++) begin
         c0 = req_log[POP + 2*j]; c1 = req_log[POP + 2*j + 1]; ok = 1'b0;
         for (int k = 0; k < GENES; k++) begin
            m = GENES'((1 << k) - 1);
            if (c0 == ((pa & ~m) | (pb & m)) && c1 == ((pb & ~m) | (pa & m))) ok = 1'b1;
         end
         check(ok, "R7 cut-point exchange", int'({c0, c1}), int'({pa, pb}));
      end

      // R8 mutation always, no crossover
      run(1, 0, 255, 2, 255);
      pick(pa, pb);
      for (int j = 0; j < POP / 2; j++) begin
         c0 = req_log[POP + 2*j]; c1 = req_log[POP + 2*j + 1];
         check($countones(c0 ^ pa) <= 1, "R8 single flip A", int'(c0), int'(pa));
         check($countones(c1 ^ pb) <= 1, "R8 single flip B", int'(c1), int'(pb));
      end

      // R9 stop on maximum score at the third candidate
      run(2, 128, 128, 5, 77);
      check(req_log.size() == 3, "R9 stop count", req_log.size(), 3);
      check(best_chrom == req_log[2], "R9 best chrom", int'(best_chrom), int'(req_log[2]));
      check(best_score == 77, "R9 best score", int'(best_score), 77);

      // R10/R11 generation budget and tie order for the best word
      run(3, 128, 64, 3, 255);
      check(req_log.size() == 3 * POP, "R10 budget of three", req_log.size(), 3 * POP);
      bc = req_log[0]; bs = score_fn(req_log[0], 0);
      for (int i = 1; i < req_log.size(); i++)
         if (score_fn(req_log[i], i) > bs) begin bs = score_fn(req_log[i], i); bc = req_log[i]; end
      check(best_score == 8'(bs), "R11 best score", int'(best_score), bs);
      check(best_chrom == bc, "R11 first-seen tie", int'(best_chrom), int'(bc));

      // R10 zero budget behaves as one generation
      run(1, 0, 0, 0, 255);
      check(req_log.size() == POP, "R10 zero budget", req_log.size(), POP);

      // R12 done held, then cleared by start
      repeat (5) @(negedge clk);
      check(done == 1, "R12 done held", int'(done), 1);
      start = 1'b1; @(negedge clk); start = 1'b0;
      check(done == 0 && best_score == 0, "R12 restart clears", int'({done, best_score}), 0);

      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

endmodule